// File: doc/BRIEF.md
# SPI FIFO Status and Edge Interrupt Unit

This unit sits beside the transmit and receive FIFOs of a serial peripheral controller. It watches both fill levels, the push and pop strobes and two state signals from the shift engine, and condenses them into a 12-bit status word. It also keeps a latched cause register, an interrupt mask and one interrupt line. The FIFO storage and the shifter are outside the block. The unit only observes them.

Interrupts are edge-based. A cause bit latches when its status flag goes from low to high. It does not latch while the flag merely stays high. Software clears a cause bit by writing a 1 to it. Each FIFO ready flag compares against its own 3-bit threshold held in a configuration register. Overflow and underflow are sticky status flags that a FIFO flush clears. A simple register bus gives access: a 2-bit word address, a write strobe, write data and combinational read data.

Register map (word address): 0 status (read-only, writes ignored), 1 cause (write 1 to clear), 2 mask, 3 configuration. In the configuration register the receive threshold sits at bits 26:24 and the transmit threshold at bits 30:28. All other configuration bits read as zero.

Top module: `fifo_irq_unit`

## Requirements
- R1: Status bits are laid out as follows. Bit 0 is transfer done and bit 1 is transfer ready, both copied from inputs. Bits 4/5 are receive empty/full and bits 6/7 are transmit empty/full. Empty means level 0 and full means level DEPTH (8). All four follow the levels in the same cycle.
- R2: Receive ready (status bit 2) is high exactly when the receive level is greater than the receive threshold (configuration bits 26:24).
- R3: Transmit ready (status bit 3) is high exactly when the free space (DEPTH minus transmit level) is greater than the transmit threshold (configuration bits 30:28).
- R4: Receive underflow/overflow (bits 8/9) and transmit underflow/overflow (bits 10/11) are sticky. Each sets one cycle after a pop from an empty FIFO or a push into a full FIFO. A push into a FIFO that is not full leaves them clear. A flush pulse clears all four.
- R5: A cause bit sets one cycle after its status flag rises from 0 to 1. A flag that stays high does not set the bit again once it has been cleared. Enabling a mask bit while its flag is already high creates no cause.
- R6: Writing to address 1 clears exactly the cause bits written as 1. Writing all ones clears every cause bit.
- R7: When a rising edge and a write-1-clear hit the same cause bit in the same cycle, the bit ends up set.
- R8: The irq output is high exactly when some cause bit and its mask bit are both 1. A mask of zero holds irq low.
- R9: After reset, cause, mask and both thresholds read 0 and irq is low. Flags that are already high when reset is released create no cause.
- R10: A write to address 0 changes no register. The mask at address 2 reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_level | input | 4 | Transmit FIFO fill level, 0 to DEPTH |
| rx_level | input | 4 | Receive FIFO fill level, 0 to DEPTH |
| tx_push | input | 1 | Write into the transmit FIFO this cycle |
| tx_pop | input | 1 | Read from the transmit FIFO this cycle |
| rx_push | input | 1 | Write into the receive FIFO this cycle |
| rx_pop | input | 1 | Read from the receive FIFO this cycle |
| fifo_flush | input | 1 | Flush pulse; clears the sticky error flags |
| xfer_done | input | 1 | Shift engine finished a word |
| xfer_ready | input | 1 | Shift engine idle and ready |
| irq | output | 1 | Interrupt request |

## Verification
Levels are driven to zero, to full and just either side of each programmed threshold. These patterns separate a greater-than compare from a greater-or-equal one, and they show whether transmit ready is computed from free space rather than fill. The cause path is driven with a held-high flag, a fresh rise, a partial clear, an all-ones clear and a rise that coincides with a clear. Together these distinguish edge latching from level latching and show the precedence between setting and clearing. Push and pop strobes are applied to full, empty and part-filled FIFOs, followed by a flush. This shows that the error flags are sticky and that a push into a FIFO with room does not set them.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int STAT_W = 12;

  localparam int ST_DONE    = 0;
  localparam int ST_XRDY    = 1;
  localparam int ST_RX_RDY  = 2;
  localparam int ST_TX_RDY  = 3;
  localparam int ST_RX_EMP  = 4;
  localparam int ST_RX_FULL = 5;
  localparam int ST_TX_EMP  = 6;
  localparam int ST_TX_FULL = 7;
  localparam int ST_RX_UDF  = 8;
  localparam int ST_RX_OVF  = 9;
  localparam int ST_TX_UDF  = 10;
  localparam int ST_TX_OVF  = 11;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_CAUSE  = 2'd1;
  localparam logic [1:0] A_MASK   = 2'd2;
  localparam logic [1:0] A_CONFIG = 2'd3;

  localparam int THR_W     = 3;
  localparam int RX_THR_LO = 24;
  localparam int TX_THR_LO = 28;
endpackage

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4,
  parameter int THR_W = 3,
  parameter bit IS_TX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic             empty,
  output logic             full,
  output logic             ready,
  output logic             ovf,
  output logic             udf
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  assign empty = (level == '0);
  assign full  = (level == DEPTH_L);

  generate
    if (IS_TX) begin : g_tx
      logic [LVL_W-1:0] space;
      assign space = DEPTH_L - level;
      assign ready = space > LVL_W'(thr);
    end else begin : g_rx
      assign ready = level > LVL_W'(thr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else if (flush) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (push && full) ovf <= 1'b1;
      if (pop && empty) udf <= 1'b1;
    end
  end

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf) && !$past(flush)) |-> ovf);
  a_r1_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r2_ready_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (IS_TX ? !full : !empty));
endmodule

// File: rtl/edge_cause_reg.sv
module edge_cause_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] clr,
  output logic [W-1:0] cause
);
  logic [W-1:0] prev;
  logic         armed;
  logic [W-1:0] rise;

  assign rise = armed ? (stat & ~prev) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      armed <= 1'b0;
      cause <= '0;
    end else begin
      prev  <= stat;
      armed <= 1'b1;
      cause <= (cause & ~clr) | rise;
    end
  end

  a_r5_cause_from_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause & ~$past(cause)) & ~$past(stat)) == '0);
  a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cause & $past(cause)) & ~$past(clr)) == '0);
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             fifo_flush,
  input  logic             xfer_done,
  input  logic             xfer_ready,
  output logic             irq
);
  logic [STAT_W-1:0] stat, cause, mask_q, clr;
  logic [THR_W-1:0]  rx_thr, tx_thr;
  logic tx_emp, tx_full, tx_rdy, tx_ovf, tx_udf;
  logic rx_emp, rx_full, rx_rdy, rx_ovf, rx_udf;

  fifo_flag_gen #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_TX(1'b1)) u_tx_flags (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .thr(tx_thr),
    .push(tx_push), .pop(tx_pop), .flush(fifo_flush),
    .empty(tx_emp), .full(tx_full), .ready(tx_rdy), .ovf(tx_ovf), .udf(tx_udf));

  fifo_flag_gen #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_TX(1'b0)) u_rx_flags (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .thr(rx_thr),
    .push(rx_push), .pop(rx_pop), .flush(fifo_flush),
    .empty(rx_emp), .full(rx_full), .ready(rx_rdy), .ovf(rx_ovf), .udf(rx_udf));

  always_comb begin
    stat             = '0;
    stat[ST_DONE]    = xfer_done;
    stat[ST_XRDY]    = xfer_ready;
    stat[ST_RX_RDY]  = rx_rdy;
    stat[ST_TX_RDY]  = tx_rdy;
    stat[ST_RX_EMP]  = rx_emp;
    stat[ST_RX_FULL] = rx_full;
    stat[ST_TX_EMP]  = tx_emp;
    stat[ST_TX_FULL] = tx_full;
    stat[ST_RX_UDF]  = rx_udf;
    stat[ST_RX_OVF]  = rx_ovf;
    stat[ST_TX_UDF]  = tx_udf;
    stat[ST_TX_OVF]  = tx_ovf;
  end

  assign clr = (bus_we && bus_addr == A_CAUSE) ? bus_wdata[STAT_W-1:0] : '0;

  edge_cause_reg #(.W(STAT_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .stat(stat), .clr(clr), .cause(cause));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rx_thr <= '0;
      tx_thr <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_MASK) mask_q <= bus_wdata[STAT_W-1:0];
      if (bus_addr == A_CONFIG) begin
        rx_thr <= bus_wdata[RX_THR_LO +: THR_W];
        tx_thr <= bus_wdata[TX_THR_LO +: THR_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STATUS: bus_rdata[STAT_W-1:0] = stat;
      A_CAUSE:  bus_rdata[STAT_W-1:0] = cause;
      A_MASK:   bus_rdata[STAT_W-1:0] = mask_q;
      default: begin
        bus_rdata[RX_THR_LO +: THR_W] = rx_thr;
        bus_rdata[TX_THR_LO +: THR_W] = tx_thr;
      end
    endcase
  end

  assign irq = |(cause & mask_q);

  a_r8_mask_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  a_r8_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cause != '0));
endmodule

// File: tb/fifo_irq_unit_bench.sv
module fifo_irq_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tx_level = '0, rx_level = '0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, fifo_flush = 0;
  logic xfer_done = 0, xfer_ready = 0;
  logic irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  fifo_irq_unit u_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_level(tx_level),
    .rx_level(rx_level), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_pop(rx_pop), .fifo_flush(fifo_flush),
    .xfer_done(xfer_done), .xfer_ready(xfer_ready), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic clear_all();
    tick();
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
    rd(2'd1, v); check("R9 cause after reset", v, 32'h0);
    rd(2'd2, v); check("R9 mask after reset", v, 32'h0);
    rd(2'd3, v); check("R9 config after reset", v, 32'h0);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);
    rd(2'd0, v); check("R1 status with empty fifos", v, 32'h58);
  endtask

  task automatic t_status();
    logic [31:0] v;
    rx_level = 4'd8; tx_level = 4'd8; xfer_done = 1; xfer_ready = 1;
    rd(2'd0, v); check("R1 status with full fifos", v, 32'hA7);
    clear_all();
    rd(2'd1, v); check("R6 all-ones clear", v, 32'h0);
  endtask

  task automatic t_rx_thr();
    logic [31:0] v;
    wr(2'd3, 32'h0300_0000);
    rd(2'd3, v); check("R2 rx threshold readback", v, 32'h0300_0000);
    rx_level = 4'd3;
    rd(2'd0, v); check("R2 rx level equal to threshold", v & 32'h4, 32'h0);
    rx_level = 4'd4;
    rd(2'd0, v); check("R2 rx level above threshold", v & 32'h4, 32'h4);
  endtask

  task automatic t_tx_thr();
    logic [31:0] v;
    wr(2'd3, 32'h5000_0000);
    tx_level = 4'd2;
    rd(2'd0, v); check("R3 tx space above threshold", v & 32'h8, 32'h8);
    tx_level = 4'd3;
    rd(2'd0, v); check("R3 tx space equal to threshold", v & 32'h8, 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    tx_level = 4'd0; rx_level = 4'd8;
    tx_push = 1; tick(); tx_push = 0;
    rd(2'd0, v); check("R4 push with room sets nothing", v & 32'hF00, 32'h0);
    rx_push = 1; tick(); rx_push = 0;
    tick(3);
    rd(2'd0, v); check("R4 rx overflow sticky", v & 32'hF00, 32'h200);
    tx_pop = 1; tick(); tx_pop = 0;
    rd(2'd0, v); check("R4 tx underflow", v & 32'hF00, 32'h600);
    fifo_flush = 1; tick(); fifo_flush = 0;
    rd(2'd0, v); check("R4 flush clears errors", v & 32'hF00, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    xfer_done = 0; tick(2);
    clear_all();
    rd(2'd1, v); check("R5 cleared before rise", v, 32'h0);
    xfer_done = 1; tick();
    rd(2'd1, v); check("R5 rise latches cause", v & 32'h1, 32'h1);
    wr(2'd1, 32'h1);
    tick(3);
    rd(2'd1, v); check("R5 held flag does not relatch", v & 32'h1, 32'h0);
    wr(2'd2, 32'h1);
    tick();
    rd(2'd1, v); check("R5 mask on high flag no cause", v & 32'h1, 32'h0);
    check("R5 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    xfer_done = 0; tick();
    xfer_done = 1; tick();
    check("R8 irq with cause and mask", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h0);
    check("R8 zero mask blocks irq", {31'b0, irq}, 32'h0);
    rd(2'd1, v); check("R8 cause kept under zero mask", v & 32'h1, 32'h1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    clear_all();
    xfer_done = 0; tick();
    xfer_done = 1;
    wr(2'd1, 32'h1);
    rd(2'd1, v); check("R7 rise wins over clear", v & 32'h1, 32'h1);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    clear_all();
    xfer_done = 0; xfer_ready = 0; tick();
    xfer_done = 1; xfer_ready = 1; tick();
    rd(2'd1, v); check("R6 two causes set", v & 32'h3, 32'h3);
    wr(2'd1, 32'h2);
    rd(2'd1, v); check("R6 partial clear", v & 32'h3, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R6 all-ones clear again", v, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(2'd2, 32'h5);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R10 mask readback after status write", v, 32'h5);
    rd(2'd1, v); check("R10 cause untouched by status write", v, 32'h0);
    rd(2'd3, v); check("R10 config untouched by status write", v, 32'h5000_0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_status();
    t_rx_thr();
    t_tx_thr();
    t_errors();
    t_edge();
    t_irq();
    t_collide();
    t_partial();
    t_map();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule